// File: doc/BRIEF.md
# Lockable Boot-Loaded Configuration Register

This block holds one 32-bit configuration word for the timer and clock logic of a chip. While the pre-boot phase is active, the boot loader presents the non-volatile configuration word with a valid strobe, together with a fail flag and a blank flag. The register takes that word only when it is trusted, meaning neither flag is set. It considers only the first strobe after reset.

Once pre-boot ends, software writes through a simple full-word write port, and a 2-bit lock code gates each write field by field. Code 00 opens every field. Code 10 opens only the watchdog clock-select field. The other two codes block everything. A blocked write raises a one-cycle reject pulse. The current contents can be read at any time, and the fields are decoded into ready-to-use values: dead-man timer limit and window, watchdog post-scale divider, and window size in eighths. The remaining fields are driven out as plain bits.

Top module: `cfg_lockreg`

## Requirements
- R1: During and after synchronous reset, rd_data reads 0x7F7FFF38 and wr_rej is 0.
- R2: While boot_phase is 1, the first boot_vld strobe with boot_fail=0 and boot_blank=0 loads boot_word from the next clock edge. Bit 6 of the stored word always reads 0.
- R3: If that first strobe has boot_fail=1 or boot_blank=1, the register keeps its reset contents.
- R4: Only the first boot_vld strobe seen while boot_phase is 1 after reset is considered. Any later strobe leaves the contents unchanged, whether the first one loaded or not.
- R5: With boot_phase=0 and lock_code=00, a write replaces all implemented bits from the next edge, and bit 6 stays 0.
- R6: With boot_phase=0 and lock_code=10, a write changes only bits 11:10, the watchdog clock select. All other bits stay unchanged.
- R7: A write made while lock_code is 01 or 11, or while boot_phase is 1, changes nothing.
- R8: wr_rej is 1 for exactly the cycle after a write made with lock_code other than 00 or with boot_phase=1. Otherwise it is 0.
- R9: dmt_limit equals 2^(c+8), where c is the code in bits 30:26. Codes 24 to 31 give 2^31.
- R10: dmt_window is 0 when the code k in bits 5:3 is 0. Otherwise it is dmt_limit - (dmt_limit >> k).
- R11: wdt_post_div equals 2^p, where p is the code in bits 20:16. Codes above 20 give 2^20.
- R12: The window code in bits 25:24 sets wdt_win_eighths: 00 gives 6, 01 gives 4, 10 gives 3, 11 gives 2.
- R13: Each single-bit and small output follows its own field:
  - dmt_en is bit 31; wdt_en is bit 23; wdt_win_off is bit 22; wdt_pgm_stop is bit 21;
  - fscm_en is bit 15; clk_sw_en is bit 14; wake_two_speed is bit 13; sosc_xtal is bit 12;
  - wdt_clk_sel is bits 11:10; posc_mode is bits 9:8; pmu_mon_sel is bit 7; acmp_wait is bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_phase | input | 1 | Pre-boot phase active |
| boot_vld | input | 1 | Configuration word valid strobe |
| boot_word | input | 32 | Configuration word from the boot loader |
| boot_fail | input | 1 | Configuration read reported a failure |
| boot_blank | input | 1 | Configuration word is blank or erased |
| lock_code | input | 2 | Write lock code |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| rd_data | output | 32 | Current register contents |
| wr_rej | output | 1 | One-cycle blocked-write pulse |
| dmt_en | output | 1 | Dead-man timer enable |
| dmt_limit | output | 32 | Dead-man timer count limit |
| dmt_window | output | 32 | Dead-man timer window value |
| wdt_en | output | 1 | Watchdog enable |
| wdt_win_eighths | output | 4 | Watchdog window size in eighths |
| wdt_win_off | output | 1 | Windowed watchdog disabled |
| wdt_pgm_stop | output | 1 | Watchdog stops during flash programming |
| wdt_post_div | output | 32 | Watchdog post-scale divider |
| wdt_clk_sel | output | 2 | Watchdog run clock select |
| fscm_en | output | 1 | Fail-safe clock monitor enable |
| clk_sw_en | output | 1 | Software clock switching enable |
| wake_two_speed | output | 1 | Two-speed wake from sleep |
| sosc_xtal | output | 1 | Secondary oscillator crystal mode |
| posc_mode | output | 2 | Primary oscillator mode |
| pmu_mon_sel | output | 1 | Power-unit test monitor select |
| acmp_wait | output | 3 | Comparator result wait count |

## Verification
The bench targets the trust and first-strobe rules. A failed or blank first word must leave reset contents, and it must also use up the single load chance. A design that re-arms on failure would accept the trusted word that follows.

The bench also targets the partial lock 10. A design that masks wrongly either ignores the clock-select field or lets neighbouring bits through, and either mistake shows up in rd_data.

The decode corners covered are:
- the reserved dead-man codes and post-scale codes above 20, which must saturate rather than wrap to a small count;
- window code 0, which must yield zero rather than a full limit;
- bit 6 written as 1, which must still read 0.

// File: rtl/cfg_lockreg_pkg.sv
package cfg_lockreg_pkg;

    localparam int unsigned CFG_W = 32;

    localparam logic [CFG_W-1:0] CFG_RST_VAL  = 32'h7F7F_FF38;
    localparam logic [CFG_W-1:0] CFG_IMPL     = 32'hFFFF_FFBF;
    localparam logic [CFG_W-1:0] CFG_CLKSEL_M = 32'h0000_0C00;

    // field positions decoded by the timer and clock logic
    localparam int unsigned POS_DMT_EN   = 31;
    localparam int unsigned POS_DMT_CNT  = 26;
    localparam int unsigned POS_WIN_SZ   = 24;
    localparam int unsigned POS_WDT_EN   = 23;
    localparam int unsigned POS_WIN_OFF  = 22;
    localparam int unsigned POS_PGM_STOP = 21;
    localparam int unsigned POS_POST     = 16;
    localparam int unsigned POS_FSCM     = 15;
    localparam int unsigned POS_CLKSW    = 14;
    localparam int unsigned POS_WAKE2    = 13;
    localparam int unsigned POS_SOSC     = 12;
    localparam int unsigned POS_WDT_CLK  = 10;
    localparam int unsigned POS_POSC     = 8;
    localparam int unsigned POS_PMU      = 7;
    localparam int unsigned POS_INTV     = 3;
    localparam int unsigned POS_ACMP     = 0;

    typedef enum logic [1:0] {
        LOCK_OPEN   = 2'b00,
        LOCK_FULL_A = 2'b01,
        LOCK_CLKSEL = 2'b10,
        LOCK_FULL_B = 2'b11
    } lock_e;

    typedef struct packed {
        logic [CFG_W-1:0] limit;
        logic [CFG_W-1:0] window;
        logic [CFG_W-1:0] post_div;
        logic [3:0]       win_eighths;
    } timer_dec_t;

    function automatic logic [3:0] win_to_eighths(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd6;
            2'b01:   return 4'd4;
            2'b10:   return 4'd3;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] lock_to_mask(input lock_e code);
        case (code)
            LOCK_OPEN:   return CFG_IMPL;
            LOCK_CLKSEL: return CFG_CLKSEL_M;
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_boot_gate.sv
module cfg_boot_gate (
    input  logic clk,
    input  logic rst,
    input  logic boot_phase,
    input  logic boot_vld,
    input  logic boot_fail,
    input  logic boot_blank,
    output logic boot_take
);
    logic seen_q;
    logic strobe;

    assign strobe    = boot_phase && boot_vld && !seen_q;
    assign boot_take = strobe && !boot_fail && !boot_blank;

    // one load chance per reset, consumed by trusted and untrusted words alike
    always_ff @(posedge clk) begin
        if (rst)         seen_q <= 1'b0;
        else if (strobe) seen_q <= 1'b1;
    end
endmodule

// File: rtl/cfg_wr_policy.sv
module cfg_wr_policy
    import cfg_lockreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_phase,
    input  logic [1:0]       lock_code,
    input  logic             wr_en,
    output logic [CFG_W-1:0] wr_mask,
    output logic             wr_rej
);
    lock_e lock;
    logic  blocked;

    assign lock    = lock_e'(lock_code);
    assign wr_mask = (wr_en && !boot_phase) ? lock_to_mask(lock) : '0;
    assign blocked = wr_en && (boot_phase || lock != LOCK_OPEN);

    always_ff @(posedge clk) begin
        if (rst) wr_rej <= 1'b0;
        else     wr_rej <= blocked;
    end
endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
    import cfg_lockreg_pkg::*;
#(
    parameter int unsigned CNT_BASE_LOG2 = 8,
    parameter int unsigned CNT_CODE_MAX  = 23,
    parameter int unsigned PSC_CODE_MAX  = 20
) (
    input  logic [4:0]  cnt_code,
    input  logic [2:0]  intv_code,
    input  logic [4:0]  post_code,
    input  logic [1:0]  win_code,
    output timer_dec_t  dec
);
    localparam int unsigned LIM_SH_W = $clog2(CFG_W);

    logic [LIM_SH_W-1:0] lim_sh;
    logic [LIM_SH_W-1:0] psc_sh;

    always_comb begin
        if (32'(cnt_code) > CNT_CODE_MAX)
            lim_sh = LIM_SH_W'(CNT_CODE_MAX + CNT_BASE_LOG2);
        else
            lim_sh = LIM_SH_W'(32'(cnt_code) + CNT_BASE_LOG2);

        if (32'(post_code) > PSC_CODE_MAX)
            psc_sh = LIM_SH_W'(PSC_CODE_MAX);
        else
            psc_sh = LIM_SH_W'(post_code);

        dec.limit       = CFG_W'(1) << lim_sh;
        dec.post_div    = CFG_W'(1) << psc_sh;
        dec.win_eighths = win_to_eighths(win_code);
        if (intv_code == 3'd0)
            dec.window = '0;
        else
            dec.window = dec.limit - (dec.limit >> intv_code);
    end
endmodule

// File: rtl/cfg_lockreg.sv
module cfg_lockreg
    import cfg_lockreg_pkg::*;
#(
    parameter int unsigned CNT_BASE_LOG2 = 8,
    parameter int unsigned CNT_CODE_MAX  = 23,
    parameter int unsigned PSC_CODE_MAX  = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        boot_phase,
    input  logic        boot_vld,
    input  logic [31:0] boot_word,
    input  logic        boot_fail,
    input  logic        boot_blank,
    input  logic [1:0]  lock_code,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        wr_rej,
    output logic        dmt_en,
    output logic [31:0] dmt_limit,
    output logic [31:0] dmt_window,
    output logic        wdt_en,
    output logic [3:0]  wdt_win_eighths,
    output logic        wdt_win_off,
    output logic        wdt_pgm_stop,
    output logic [31:0] wdt_post_div,
    output logic [1:0]  wdt_clk_sel,
    output logic        fscm_en,
    output logic        clk_sw_en,
    output logic        wake_two_speed,
    output logic        sosc_xtal,
    output logic [1:0]  posc_mode,
    output logic        pmu_mon_sel,
    output logic [2:0]  acmp_wait
);
    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] wr_mask;
    logic             boot_take;
    timer_dec_t       dec;

    cfg_boot_gate u_boot (
        .clk        (clk),
        .rst        (rst),
        .boot_phase (boot_phase),
        .boot_vld   (boot_vld),
        .boot_fail  (boot_fail),
        .boot_blank (boot_blank),
        .boot_take  (boot_take)
    );

    cfg_wr_policy u_policy (
        .clk        (clk),
        .rst        (rst),
        .boot_phase (boot_phase),
        .lock_code  (lock_code),
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .wr_rej     (wr_rej)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RST_VAL;
        else if (boot_take)
            cfg_q <= boot_word & CFG_IMPL;
        else
            cfg_q <= (cfg_q & ~wr_mask) | (wr_data & wr_mask);
    end

    cfg_field_decode #(
        .CNT_BASE_LOG2 (CNT_BASE_LOG2),
        .CNT_CODE_MAX  (CNT_CODE_MAX),
        .PSC_CODE_MAX  (PSC_CODE_MAX)
    ) u_dec (
        .cnt_code  (cfg_q[POS_DMT_CNT +: 5]),
        .intv_code (cfg_q[POS_INTV +: 3]),
        .post_code (cfg_q[POS_POST +: 5]),
        .win_code  (cfg_q[POS_WIN_SZ +: 2]),
        .dec       (dec)
    );

    assign rd_data         = cfg_q;
    assign dmt_limit       = dec.limit;
    assign dmt_window      = dec.window;
    assign wdt_post_div    = dec.post_div;
    assign wdt_win_eighths = dec.win_eighths;

    assign dmt_en         = cfg_q[POS_DMT_EN];
    assign wdt_en         = cfg_q[POS_WDT_EN];
    assign wdt_win_off    = cfg_q[POS_WIN_OFF];
    assign wdt_pgm_stop   = cfg_q[POS_PGM_STOP];
    assign fscm_en        = cfg_q[POS_FSCM];
    assign clk_sw_en      = cfg_q[POS_CLKSW];
    assign wake_two_speed = cfg_q[POS_WAKE2];
    assign sosc_xtal      = cfg_q[POS_SOSC];
    assign wdt_clk_sel    = cfg_q[POS_WDT_CLK +: 2];
    assign posc_mode      = cfg_q[POS_POSC +: 2];
    assign pmu_mon_sel    = cfg_q[POS_PMU];
    assign acmp_wait      = cfg_q[POS_ACMP +: 3];
endmodule

// File: rtl/cfg_lockreg_chk.sv
module cfg_lockreg_chk (
    input logic        clk,
    input logic        rst,
    input logic        boot_phase,
    input logic        boot_vld,
    input logic        boot_fail,
    input logic        boot_blank,
    input logic [1:0]  lock_code,
    input logic        wr_en,
    input logic [31:0] rd_data,
    input logic        wr_rej,
    input logic [31:0] dmt_limit,
    input logic [31:0] wdt_post_div
);
    // R8: a blocked write is answered by a reject pulse on the next cycle
    a_r8_rej_on_block: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (boot_phase || lock_code != 2'b00)) |=> wr_rej);

    // R8: no write, no reject
    a_r8_no_rej_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_rej);

    // R7: fully locked outside pre-boot, the contents cannot move
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (rst)
        (!boot_phase && (lock_code == 2'b01 || lock_code == 2'b11)) |=> $stable(rd_data));

    // R6: partial lock touches only the clock-select field
    a_r6_clksel_only: assert property (@(posedge clk) disable iff (rst)
        (!boot_phase && lock_code == 2'b10) |=>
            (rd_data[31:12] == $past(rd_data[31:12]) && rd_data[9:0] == $past(rd_data[9:0])));

    // R3: an untrusted boot word never changes the contents
    a_r3_untrusted_hold: assert property (@(posedge clk) disable iff (rst)
        (boot_phase && boot_vld && (boot_fail || boot_blank) && !wr_en) |=> $stable(rd_data));

    // R2, R5: the unimplemented bit never reads as 1
    a_r5_bit6_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[6] == 1'b0);

    // R9: the dead-man limit is always a single power of two
    a_r9_limit_pow2: assert property (@(posedge clk) disable iff (rst)
        $countones(dmt_limit) == 1);

    // R11: the post-scale divider is a power of two no larger than 2^20
    a_r11_post_pow2: assert property (@(posedge clk) disable iff (rst)
        ($countones(wdt_post_div) == 1 && wdt_post_div <= 32'h0010_0000));
endmodule

bind cfg_lockreg cfg_lockreg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .boot_phase   (boot_phase),
    .boot_vld     (boot_vld),
    .boot_fail    (boot_fail),
    .boot_blank   (boot_blank),
    .lock_code    (lock_code),
    .wr_en        (wr_en),
    .rd_data      (rd_data),
    .wr_rej       (wr_rej),
    .dmt_limit    (dmt_limit),
    .wdt_post_div (wdt_post_div)
);

// File: tb/sim_cfg_lockreg.sv
`timescale 1ns/1ps
module sim_cfg_lockreg;

    logic        clk = 1'b0;
    logic        rst;
    logic        boot_phase, boot_vld, boot_fail, boot_blank;
    logic [31:0] boot_word;
    logic [1:0]  lock_code;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data, dmt_limit, dmt_window, wdt_post_div;
    logic        wr_rej, dmt_en, wdt_en, wdt_win_off, wdt_pgm_stop;
    logic [3:0]  wdt_win_eighths;
    logic [1:0]  wdt_clk_sel, posc_mode;
    logic        fscm_en, clk_sw_en, wake_two_speed, sosc_xtal, pmu_mon_sel;
    logic [2:0]  acmp_wait;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cfg_lockreg u0 (
        .clk(clk), .rst(rst), .boot_phase(boot_phase), .boot_vld(boot_vld),
        .boot_word(boot_word), .boot_fail(boot_fail), .boot_blank(boot_blank),
        .lock_code(lock_code), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wr_rej(wr_rej), .dmt_en(dmt_en),
        .dmt_limit(dmt_limit), .dmt_window(dmt_window), .wdt_en(wdt_en),
        .wdt_win_eighths(wdt_win_eighths), .wdt_win_off(wdt_win_off),
        .wdt_pgm_stop(wdt_pgm_stop), .wdt_post_div(wdt_post_div),
        .wdt_clk_sel(wdt_clk_sel), .fscm_en(fscm_en), .clk_sw_en(clk_sw_en),
        .wake_two_speed(wake_two_speed), .sosc_xtal(sosc_xtal),
        .posc_mode(posc_mode), .pmu_mon_sel(pmu_mon_sel), .acmp_wait(acmp_wait)
    );

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] rd;
        logic [31:0] limit;
        logic [31:0] window;
        logic [31:0] post;
        logic [3:0]  win;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0008, 32'h0000_0008, 32'h0000_0100, 32'h0000_0080, 32'h0000_0001, 4'd6},
        '{32'h5D14_0038, 32'h5D14_0038, 32'h8000_0000, 32'h7F00_0000, 32'h0010_0000, 4'd4},
        '{32'h6215_0000, 32'h6215_0000, 32'h8000_0000, 32'h0000_0000, 32'h0010_0000, 4'd3},
        '{32'h7F05_0010, 32'h7F05_0010, 32'h8000_0000, 32'h6000_0000, 32'h0000_0020, 4'd2},
        '{32'h140A_0020, 32'h140A_0020, 32'h0000_2000, 32'h0000_1E00, 32'h0000_0400, 4'd6},
        '{32'h140A_0060, 32'h140A_0020, 32'h0000_2000, 32'h0000_1E00, 32'h0000_0400, 4'd6}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; boot_phase = 1'b1; boot_vld = 1'b0; boot_fail = 1'b0;
        boot_blank = 1'b0; boot_word = '0; lock_code = 2'b00; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic boot_strobe(input logic [31:0] w, input logic f, input logic b);
        boot_word = w; boot_fail = f; boot_blank = b; boot_vld = 1'b1;
        @(negedge clk);
        boot_vld = 1'b0; boot_fail = 1'b0; boot_blank = 1'b0;
    endtask

    // drive a write for one cycle; on return the write has taken effect and wr_rej shows its answer
    task automatic do_write(input logic [1:0] lk, input logic [31:0] d);
        lock_code = lk; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // ---- reset state: R1, with reset decode R9..R12 ----
        do_reset();
        chk("R1 reset rd_data", rd_data, 32'h7F7F_FF38);
        chk("R1 reset wr_rej", 32'(wr_rej), 32'd0);
        chk("R9 reset limit", dmt_limit, 32'h8000_0000);
        chk("R10 reset window", dmt_window, 32'h7F00_0000);
        chk("R11 reset post", wdt_post_div, 32'h0010_0000);
        chk("R12 reset win", 32'(wdt_win_eighths), 32'd2);

        // ---- failed first strobe keeps reset values and uses the only chance ----
        boot_strobe(32'h1234_5678, 1'b1, 1'b0);
        chk("R3 fail ignored", rd_data, 32'h7F7F_FF38);
        boot_strobe(32'h1234_5678, 1'b0, 1'b0);
        chk("R4 strobe after fail ignored", rd_data, 32'h7F7F_FF38);

        // ---- blank first strobe ----
        do_reset();
        boot_strobe(32'h0000_0000, 1'b0, 1'b1);
        chk("R3 blank ignored", rd_data, 32'h7F7F_FF38);

        // ---- trusted load, then later strobe and pre-boot writes ignored ----
        do_reset();
        boot_strobe(32'hA5A5_C3F7, 1'b0, 1'b0);
        chk("R2 trusted load bit6 cleared", rd_data, 32'hA5A5_C3B7);
        boot_strobe(32'h0000_0000, 1'b0, 1'b0);
        chk("R4 second strobe ignored", rd_data, 32'hA5A5_C3B7);
        do_write(2'b00, 32'h0000_0000);
        chk("R7 pre-boot write ignored", rd_data, 32'hA5A5_C3B7);
        chk("R8 pre-boot write rejected", 32'(wr_rej), 32'd1);
        @(negedge clk);
        chk("R8 reject lasts one cycle", 32'(wr_rej), 32'd0);

        // ---- open lock: walk the decode table (R5, R9..R12) ----
        boot_phase = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            do_write(2'b00, VECS[i].word);
            chk($sformatf("R5 open write v%0d", i), rd_data, VECS[i].rd);
            chk($sformatf("R8 open no reject v%0d", i), 32'(wr_rej), 32'd0);
            chk($sformatf("R9 limit v%0d", i), dmt_limit, VECS[i].limit);
            chk($sformatf("R10 window v%0d", i), dmt_window, VECS[i].window);
            chk($sformatf("R11 post v%0d", i), wdt_post_div, VECS[i].post);
            chk($sformatf("R12 win v%0d", i), 32'(wdt_win_eighths), 32'(VECS[i].win));
        end

        // ---- single-bit and small fields: R13 ----
        do_write(2'b00, 32'h80E0_A685);
        chk("R13 dmt_en", 32'(dmt_en), 32'd1);
        chk("R13 wdt_en", 32'(wdt_en), 32'd1);
        chk("R13 wdt_win_off", 32'(wdt_win_off), 32'd1);
        chk("R13 wdt_pgm_stop", 32'(wdt_pgm_stop), 32'd1);
        chk("R13 fscm_en", 32'(fscm_en), 32'd1);
        chk("R13 clk_sw_en", 32'(clk_sw_en), 32'd0);
        chk("R13 wake_two_speed", 32'(wake_two_speed), 32'd1);
        chk("R13 sosc_xtal", 32'(sosc_xtal), 32'd0);
        chk("R13 wdt_clk_sel", 32'(wdt_clk_sel), 32'd1);
        chk("R13 posc_mode", 32'(posc_mode), 32'd2);
        chk("R13 pmu_mon_sel", 32'(pmu_mon_sel), 32'd1);
        chk("R13 acmp_wait", 32'(acmp_wait), 32'd5);

        // ---- partial lock: only bits 11:10 move (R6) ----
        do_write(2'b10, 32'h0000_0C00);
        chk("R6 clksel only", rd_data, 32'h80E0_AE85);
        chk("R8 partial lock rejected", 32'(wr_rej), 32'd1);
        do_write(2'b10, 32'h7F1F_F3FF);
        chk("R6 clksel cleared, rest kept", rd_data, 32'h80E0_A285);

        // ---- full locks: nothing moves (R7) ----
        do_write(2'b01, 32'h0000_0000);
        chk("R7 lock01 ignored", rd_data, 32'h80E0_A285);
        chk("R8 lock01 rejected", 32'(wr_rej), 32'd1);
        do_write(2'b11, 32'hFFFF_FFFF);
        chk("R7 lock11 ignored", rd_data, 32'h80E0_A285);
        chk("R8 lock11 rejected", 32'(wr_rej), 32'd1);
        @(negedge clk);
        chk("R8 reject falls when idle", 32'(wr_rej), 32'd0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule